// File: doc/BRIEF.md
# SD Host Command Issue Sequencer

This block takes one command request for an SD/MMC host controller and turns it into the ordered series of register writes that start the command. A request carries an opcode, a 32-bit argument, response flags (present, 136-bit, CRC checked, busy-type), a stop indication implied by the opcode, and an optional data phase with block count, block size, direction and DMA address. The sequencer builds the interrupt-enable word, the packet length and the send word from these fields. It then drives them onto a narrow register-write port in a fixed order.

Before issuing the send word, the block waits for the command engine's busy flag to clear. If the flag stays set for `TIMEOUT_CYC` cycles, the block pulses a soft-reset vector for one cycle and then carries on with the issue. Data commands get a one-cycle DMA-configure strobe just before the send. The send word leaves with a single-cycle strobe. New requests are refused while a sequence is in flight.

Top module: `sdh_cmd_issue`

## Requirements
- R1: An accepted request without data produces register writes in the order interrupt-enable (select 0), status clear (select 1), argument (select 2), packet length (select 3), followed by the send strobe; the interrupt-enable write appears in the cycle after acceptance.
- R2: An accepted request with data adds an address write (select 4) after the packet length, and a one-cycle DMA-configure strobe (carrying the direction, 1 = write) immediately before the send strobe.
- R3: Send word fields: bits [5:0] opcode, bit 6 response present, bit 9 data present, bit 10 write direction (data only), bits [31:16] the block count minus one (zero without data).
- R4: Bit 8 (no CRC check) is set when CRC checking is not requested or when the response is 136 bits; bit 7 is set for a 136-bit response.
- R5: Bit 11 is set for a busy-type response; bit 12 is set when the opcode is 12 (stop transmission).
- R6: The packet-length write carries the block size when it is below 512, and 0 for a block size of 512 or for a command without data.
- R7: The interrupt-enable word always has bits 1 to 6 set (response CRC error, response timeout, data CRC error, data timeout, RX FIFO full, TX FIFO empty) and exactly one completion bit: bit 0 (response OK) without data, bit 8 (DMA done) for a write or when `flush_all_hw` is 1, otherwise bit 7 (transfer OK).
- R8: The status-clear write carries 0x1FF, the argument write carries the request argument, and the address write carries the request DMA address.
- R9: While `eng_busy` is 1 the send strobe is held back; once it drops, the send (or DMA-configure) follows with no soft reset.
- R10: If `eng_busy` stays 1 for `TIMEOUT_CYC` cycles of waiting, `soft_rst` is 6'b111111 for exactly one cycle, TIMEOUT_CYC+1 cycles after the last pre-wait register write, and the sequence then completes.
- R11: `req_ready` is 0 from the cycle after acceptance until the cycle after the send strobe; requests presented meanwhile produce no register writes or strobes.
- R12: After reset `req_ready` is 1 and `reg_we`, `soft_rst`, `dma_cfg_strobe` and `send_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_all_hw | input | 1 | 1 when hardware flushes every command (selects DMA-done completion for reads) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_opcode | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rsp_present | input | 1 | Command expects a response |
| req_rsp_long | input | 1 | Response is 136 bits |
| req_rsp_crc | input | 1 | Response CRC is checked |
| req_rsp_busy | input | 1 | Busy-type response |
| req_has_data | input | 1 | Command has a data phase |
| req_write | input | 1 | Data phase writes to the card |
| req_blocks | input | BLKCNT_W | Number of blocks (1 or more) |
| req_blksz | input | BLKSZ_W | Block size in bytes (1..512) |
| req_dma_addr | input | 32 | DMA buffer address |
| eng_busy | input | 1 | Command engine busy flag |
| reg_we | output | 1 | Register write strobe |
| reg_sel | output | 3 | Register select for the write |
| reg_wdata | output | 32 | Register write data |
| soft_rst | output | 6 | Soft reset: main control, RX FIFO, TX FIFO, PHY RX, PHY TX, DMA interface |
| dma_cfg_strobe | output | 1 | DMA configure pulse (data commands) |
| dma_cfg_write | output | 1 | Direction with the DMA configure pulse |
| send_strobe | output | 1 | One-cycle send strobe |
| send_word | output | 32 | Send word, valid with the strobe |

## Verification
A wrong sequencer state shows at once as a register write with the wrong select, or in the wrong place in the order. It can also show as a missing address write, or as a DMA strobe on a command without data. The scoreboard catches each of these at the first event that differs from the expected stream. A broken wait counter shows as a soft reset that arrives early, arrives late, or arrives when it should not. The reset cycle is checked against an exact offset from the last register write. A wrongly packed field shows in the one send word of that command.

// File: rtl/sdh_pkg.sv
// Package: shared encodings for the SD host command issue sequencer.
// Assumes a 32-bit register data path and a 3-bit register select.
package sdh_pkg;

    // Register select codes on the write port (issue order)
    localparam logic [2:0] SEL_IEN  = 3'd0;
    localparam logic [2:0] SEL_CLR  = 3'd1;
    localparam logic [2:0] SEL_ARG  = 3'd2;
    localparam logic [2:0] SEL_PLEN = 3'd3;
    localparam logic [2:0] SEL_ADDR = 3'd4;

    // Send word bit positions
    localparam int SB_RESP   = 6;
    localparam int SB_LONG   = 7;
    localparam int SB_NOCRC  = 8;
    localparam int SB_DATA   = 9;
    localparam int SB_WRITE  = 10;
    localparam int SB_R1B    = 11;
    localparam int SB_STOP   = 12;
    localparam int SB_PACKS  = 16;

    // Interrupt enable bit positions
    localparam int IB_RESP_OK   = 0;
    localparam int IB_XFER_OK   = 7;
    localparam int IB_DMA_DONE  = 8;
    localparam logic [31:0] IEN_ALWAYS = 32'h0000_007E;
    localparam logic [31:0] IRQ_ALL    = 32'h0000_01FF;

    localparam logic [5:0] OPC_STOP = 6'd12;
    localparam int         RST_W    = 6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_IEN, ST_CLR, ST_ARG, ST_PLEN, ST_ADDR,
        ST_WAIT, ST_RST, ST_DMA, ST_SEND
    } seq_state_t;

endpackage

// File: rtl/sdh_desc_build.sv
// Module: sdh_desc_build
// Builds the send word, interrupt-enable word and packet length from the
// request fields. Purely combinational; the caller registers the results.
// Assumes BLKCNT_W <= 16 so the packet count fits in bits [31:16].
module sdh_desc_build
    import sdh_pkg::*;
#(
    parameter int BLKCNT_W = 16,
    parameter int BLKSZ_W  = 10,
    parameter int MAX_BLK  = 512
) (
    input  logic [5:0]          opcode,
    input  logic                rsp_present,
    input  logic                rsp_long,
    input  logic                rsp_crc,
    input  logic                rsp_busy,
    input  logic                has_data,
    input  logic                is_write,
    input  logic [BLKCNT_W-1:0] blocks,
    input  logic [BLKSZ_W-1:0]  blksz,
    input  logic                flush_all,
    output logic [31:0]         send_word,
    output logic [31:0]         ien_word,
    output logic [31:0]         plen_word
);
    localparam int PLEN_W = $clog2(MAX_BLK);

    logic [BLKCNT_W-1:0] packs_m1;

    // Packet count minus one, only meaningful with data
    always_comb packs_m1 = has_data ? blocks - BLKCNT_W'(1) : '0;

    // Assemble the send word field by field
    always_comb begin
        send_word              = '0;
        send_word[5:0]         = opcode;
        send_word[SB_RESP]     = rsp_present;
        send_word[SB_LONG]     = rsp_long;
        send_word[SB_NOCRC]    = rsp_long | ~rsp_crc;
        send_word[SB_DATA]     = has_data;
        send_word[SB_WRITE]    = has_data & is_write;
        send_word[SB_R1B]      = rsp_busy;
        send_word[SB_STOP]     = (opcode == OPC_STOP);
        send_word[SB_PACKS +: BLKCNT_W] = packs_m1;
    end

    // Interrupt enables: fixed error set plus one completion source
    always_comb begin
        ien_word = IEN_ALWAYS;
        if (!has_data)
            ien_word[IB_RESP_OK] = 1'b1;
        else if (is_write || flush_all)
            ien_word[IB_DMA_DONE] = 1'b1;
        else
            ien_word[IB_XFER_OK] = 1'b1;
    end

    // Packet length: full-size blocks and no-data commands encode as zero
    always_comb begin
        plen_word = '0;
        if (has_data && (int'(blksz) < MAX_BLK))
            plen_word[PLEN_W-1:0] = blksz[PLEN_W-1:0];
    end

endmodule

// File: rtl/sdh_idle_wait.sv
// Module: sdh_idle_wait
// Polls the command-engine busy flag while the sequencer is waiting.
// Reports idle as soon as the flag is low, or expiry after TIMEOUT_CYC
// consecutive busy cycles. Assumes 'active' stays high until done/expired.
module sdh_idle_wait #(
    parameter int TIMEOUT_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic eng_busy,
    output logic done,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    // Count busy cycles while waiting; clear whenever not waiting
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            cnt <= '0;
        else if (eng_busy && (int'(cnt) < TIMEOUT_CYC - 1))
            cnt <= cnt + CNT_W'(1);
    end

    // Exit conditions of the wait
    always_comb begin
        done    = active & ~eng_busy;
        expired = active & eng_busy & (int'(cnt) == TIMEOUT_CYC - 1);
    end

    // R10: counter starts from zero at each new wait
    a_r10_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !$past(active)) |-> (cnt == '0));

    // R10: counter never passes its limit
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < TIMEOUT_CYC);

endmodule

// File: rtl/sdh_cmd_issue.sv
// Module: sdh_cmd_issue (top)
// Accepts one command request, registers its descriptor and walks the
// issue sequence: interrupt enables, status clear, argument, packet
// length, address (data only), idle wait with timeout reset, DMA
// configure (data only), send. Assumes one request in flight at a time.
module sdh_cmd_issue
    import sdh_pkg::*;
#(
    parameter int BLKCNT_W    = 16,
    parameter int BLKSZ_W     = 10,
    parameter int MAX_BLK     = 512,
    parameter int TIMEOUT_CYC = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush_all_hw,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [5:0]          req_opcode,
    input  logic [31:0]         req_arg,
    input  logic                req_rsp_present,
    input  logic                req_rsp_long,
    input  logic                req_rsp_crc,
    input  logic                req_rsp_busy,
    input  logic                req_has_data,
    input  logic                req_write,
    input  logic [BLKCNT_W-1:0] req_blocks,
    input  logic [BLKSZ_W-1:0]  req_blksz,
    input  logic [31:0]         req_dma_addr,
    input  logic                eng_busy,
    output logic                reg_we,
    output logic [2:0]          reg_sel,
    output logic [31:0]         reg_wdata,
    output logic [RST_W-1:0]    soft_rst,
    output logic                dma_cfg_strobe,
    output logic                dma_cfg_write,
    output logic                send_strobe,
    output logic [31:0]         send_word
);
    seq_state_t state, state_nx;
    logic [31:0] b_send, b_ien, b_plen;
    logic [31:0] d_send, d_ien, d_plen, d_arg, d_addr;
    logic        d_data, d_write;
    logic        accept, wait_done, wait_exp;

    sdh_desc_build #(
        .BLKCNT_W(BLKCNT_W), .BLKSZ_W(BLKSZ_W), .MAX_BLK(MAX_BLK)
    ) build_i (
        .opcode(req_opcode), .rsp_present(req_rsp_present),
        .rsp_long(req_rsp_long), .rsp_crc(req_rsp_crc),
        .rsp_busy(req_rsp_busy), .has_data(req_has_data),
        .is_write(req_write), .blocks(req_blocks), .blksz(req_blksz),
        .flush_all(flush_all_hw), .send_word(b_send), .ien_word(b_ien),
        .plen_word(b_plen)
    );

    sdh_idle_wait #(.TIMEOUT_CYC(TIMEOUT_CYC)) wait_i (
        .clk(clk), .rst_n(rst_n), .active(state == ST_WAIT),
        .eng_busy(eng_busy), .done(wait_done), .expired(wait_exp)
    );

    // Handshake: only idle accepts
    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_valid & req_ready;
    end

    // Capture the built descriptor on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_send <= '0; d_ien <= '0; d_plen <= '0;
            d_arg <= '0; d_addr <= '0; d_data <= 1'b0; d_write <= 1'b0;
        end else if (accept) begin
            d_send  <= b_send;
            d_ien   <= b_ien;
            d_plen  <= b_plen;
            d_arg   <= req_arg;
            d_addr  <= req_dma_addr;
            d_data  <= req_has_data;
            d_write <= req_write;
        end
    end

    // Next-state logic of the issue sequence
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_IEN;
            ST_IEN:  state_nx = ST_CLR;
            ST_CLR:  state_nx = ST_ARG;
            ST_ARG:  state_nx = ST_PLEN;
            ST_PLEN: state_nx = d_data ? ST_ADDR : ST_WAIT;
            ST_ADDR: state_nx = ST_WAIT;
            ST_WAIT: begin
                if (wait_done)     state_nx = d_data ? ST_DMA : ST_SEND;
                else if (wait_exp) state_nx = ST_RST;
            end
            ST_RST:  state_nx = d_data ? ST_DMA : ST_SEND;
            ST_DMA:  state_nx = ST_SEND;
            ST_SEND: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Register-write port decode
    always_comb begin
        reg_we    = 1'b1;
        reg_sel   = SEL_IEN;
        reg_wdata = '0;
        unique case (state)
            ST_IEN:  begin reg_sel = SEL_IEN;  reg_wdata = d_ien;   end
            ST_CLR:  begin reg_sel = SEL_CLR;  reg_wdata = IRQ_ALL; end
            ST_ARG:  begin reg_sel = SEL_ARG;  reg_wdata = d_arg;   end
            ST_PLEN: begin reg_sel = SEL_PLEN; reg_wdata = d_plen;  end
            ST_ADDR: begin reg_sel = SEL_ADDR; reg_wdata = d_addr;  end
            default: reg_we = 1'b0;
        endcase
    end

    // Strobes for reset, DMA configure and send
    always_comb begin
        soft_rst       = (state == ST_RST) ? {RST_W{1'b1}} : '0;
        dma_cfg_strobe = (state == ST_DMA);
        dma_cfg_write  = (state == ST_DMA) & d_write;
        send_strobe    = (state == ST_SEND);
        send_word      = d_send;
    end

    // R1: the interrupt-enable write follows acceptance directly
    a_r1_first_ien: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (reg_we && reg_sel == SEL_IEN));

    // R11: no acceptance while a sequence runs
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R2: data commands configure DMA right before sending
    a_r2_dma_before_send: assert property (@(posedge clk) disable iff (!rst_n)
        (send_strobe && send_word[SB_DATA]) |-> $past(dma_cfg_strobe));

    // R3: the send strobe lasts one cycle
    a_r3_send_single: assert property (@(posedge clk) disable iff (!rst_n)
        send_strobe |=> !send_strobe);

    // R4: a long response never asks for CRC checking
    a_r4_long_nocrc: assert property (@(posedge clk) disable iff (!rst_n)
        (send_strobe && send_word[SB_LONG]) |-> send_word[SB_NOCRC]);

    // R10: a soft reset is followed at once by the rest of the sequence
    a_r10_rst_then_go: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst != '0) |=> (dma_cfg_strobe || send_strobe));

    // R10: soft reset only after the engine was seen busy
    a_r10_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst != '0) |-> $past(eng_busy));

endmodule

// File: tb/sdh_cmd_issue_tb.sv
// Scoreboard bench: the driver pushes expected port events, the monitor
// pops and compares them as they appear at the outputs.
module sdh_cmd_issue_tb_top;
    localparam int TO = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_all_hw = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_opcode = '0;
    logic [31:0] req_arg = '0;
    logic        req_rsp_present = 1'b0, req_rsp_long = 1'b0;
    logic        req_rsp_crc = 1'b0, req_rsp_busy = 1'b0;
    logic        req_has_data = 1'b0, req_write = 1'b0;
    logic [15:0] req_blocks = '0;
    logic [9:0]  req_blksz = '0;
    logic [31:0] req_dma_addr = '0;
    logic        eng_busy = 1'b0;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [5:0]  soft_rst;
    logic        dma_cfg_strobe, dma_cfg_write, send_strobe;
    logic [31:0] send_word;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_wr_cyc = 0;
    int rst_cyc = -1;

    // Event: [35:32] kind (0..4 register select, 8 reset, 9 DMA, 10 send)
    logic [35:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    sdh_cmd_issue #(.TIMEOUT_CYC(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush_all_hw(flush_all_hw),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_arg(req_arg),
        .req_rsp_present(req_rsp_present), .req_rsp_long(req_rsp_long),
        .req_rsp_crc(req_rsp_crc), .req_rsp_busy(req_rsp_busy),
        .req_has_data(req_has_data), .req_write(req_write),
        .req_blocks(req_blocks), .req_blksz(req_blksz),
        .req_dma_addr(req_dma_addr), .eng_busy(eng_busy),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .soft_rst(soft_rst), .dma_cfg_strobe(dma_cfg_strobe),
        .dma_cfg_write(dma_cfg_write), .send_strobe(send_strobe),
        .send_word(send_word)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input logic [35:0] ev);
        if (exp_q.size() == 0) begin
            check("R11 unexpected event", ev, 36'h0);
        end else begin
            automatic string t = tag_q.pop_front();
            check(t, ev, exp_q.pop_front());
        end
    endtask

    // Monitor: sample outputs between edges and compare against the queue
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (reg_we) begin
                last_wr_cyc = cyc;
                compare({1'b0, reg_sel, reg_wdata});
            end
            if (soft_rst != '0) begin
                rst_cyc = cyc;
                compare({4'd8, 26'h0, soft_rst});
            end
            if (dma_cfg_strobe) compare({4'd9, 31'h0, dma_cfg_write});
            if (send_strobe)    compare({4'd10, send_word});
        end
    end

    function automatic logic [31:0] exp_send(input logic [5:0] op, input logic rp,
        input logic lg, input logic crc, input logic bz, input logic dt,
        input logic wr, input logic [15:0] nb);
        logic [31:0] w;
        w = {26'h0, op};
        w[6] = rp; w[7] = lg; w[8] = lg | ~crc; w[9] = dt; w[10] = dt & wr;
        w[11] = bz; w[12] = (op == 6'd12);
        w[31:16] = dt ? nb - 16'd1 : 16'd0;
        return w;
    endfunction

    // Driver: push expected events, present the request, wait for completion
    task automatic issue(input logic [5:0] op, input logic [31:0] arg,
        input logic rp, input logic lg, input logic crc, input logic bz,
        input logic dt, input logic wr, input logic [15:0] nb,
        input logic [9:0] bs, input logic [31:0] ad, input logic fl,
        input logic expect_rst);
        logic [31:0] ien;
        ien = 32'h7E;
        if (!dt) ien[0] = 1'b1;
        else if (wr || fl) ien[8] = 1'b1;
        else ien[7] = 1'b1;
        exp_q.push_back({4'd0, ien});           tag_q.push_back("R7 interrupt enables / R1 order");
        exp_q.push_back({4'd1, 32'h1FF});       tag_q.push_back("R8 status clear / R1 order");
        exp_q.push_back({4'd2, arg});           tag_q.push_back("R8 argument / R1 order");
        exp_q.push_back({4'd3, (dt && bs < 10'd512) ? {22'h0, bs} : 32'h0});
        tag_q.push_back("R6 packet length");
        if (dt) begin
            exp_q.push_back({4'd4, ad});        tag_q.push_back("R2 address write");
        end
        if (expect_rst) begin
            exp_q.push_back({4'd8, 32'h3F});    tag_q.push_back("R10 soft reset");
        end
        if (dt) begin
            exp_q.push_back({4'd9, 31'h0, wr}); tag_q.push_back("R2 DMA configure");
        end
        exp_q.push_back({4'd10, exp_send(op, rp, lg, crc, bz, dt, wr, nb)});
        tag_q.push_back("R3 R4 R5 send word");
        @(negedge clk);
        req_opcode = op; req_arg = arg; req_rsp_present = rp; req_rsp_long = lg;
        req_rsp_crc = crc; req_rsp_busy = bz; req_has_data = dt; req_write = wr;
        req_blocks = nb; req_blksz = bs; req_dma_addr = ad; flush_all_hw = fl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 ready low after accept", {35'h0, req_ready}, 36'h0);
        while (!req_ready) @(negedge clk);
        check("R1 R2 all expected events seen", 36'(exp_q.size()), 36'h0);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, run hung");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 ready after reset", {35'h0, req_ready}, 36'h1);
        check("R12 strobes idle", {26'h0, reg_we, soft_rst, dma_cfg_strobe, send_strobe},
              36'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3: no data, short response with CRC
        issue(6'd13, 32'hDEAD_BEEF, 1, 0, 1, 0, 0, 0, 16'd0, 10'd0, 32'h0, 0, 0);
        // R2 R6 R7: read, 512-byte blocks, software flush
        issue(6'd18, 32'h0000_1000, 1, 0, 1, 0, 1, 0, 16'd4, 10'd512, 32'h8000_0000, 0, 0);
        // R2 R6 R7: write, small block
        issue(6'd24, 32'h0000_0200, 1, 0, 1, 0, 1, 1, 16'd1, 10'd64, 32'h1234_5670, 0, 0);
        // R7: read with hardware flush, block size just below 512
        issue(6'd17, 32'h55AA_55AA, 1, 0, 1, 0, 1, 0, 16'd300, 10'd511, 32'h0BAD_F00D, 1, 0);
        // R4: long response
        issue(6'd2, 32'h0, 1, 1, 1, 0, 0, 0, 16'd0, 10'd0, 32'h0, 0, 0);
        // R4: response without CRC check
        issue(6'd41, 32'h00FF_8000, 1, 0, 0, 0, 0, 0, 16'd0, 10'd0, 32'h0, 0, 0);
        // R5: stop transmission with busy response
        issue(6'd12, 32'h0, 1, 0, 1, 1, 0, 0, 16'd0, 10'd0, 32'h0, 0, 0);

        // R9 R11: engine busy for a while, then idle; request during busy ignored
        eng_busy = 1'b1;
        fork
            issue(6'd7, 32'h0001_0000, 1, 0, 1, 1, 0, 0, 16'd0, 10'd0, 32'h0, 0, 0);
            begin
                repeat (2) @(negedge clk);
                req_valid = 1'b1; req_opcode = 6'd40;
                repeat (2) @(negedge clk);
                req_valid = 1'b0;
                repeat (10) @(negedge clk);
                eng_busy = 1'b0;
            end
        join
        check("R9 no soft reset on short busy", 36'(rst_cyc), 36'hF_FFFF_FFFF);

        // R10: engine stuck busy, data write command
        eng_busy = 1'b1;
        fork
            issue(6'd25, 32'h0000_0040, 1, 0, 1, 0, 1, 1, 16'd8, 10'd512, 32'hCAFE_0000, 0, 1);
            begin
                while (rst_cyc < 0) @(negedge clk);
                check("R10 reset timing", 36'(rst_cyc - last_wr_cyc), 36'(TO + 1));
            end
        join
        eng_busy = 1'b0;

        repeat (3) @(negedge clk);
        check("R11 no stray events", 36'(exp_q.size()), 36'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule